// File: doc/BRIEF.md
# MDIO management station controller

This block is the MAC-side master of a two-wire management bus. It divides the system clock down to a management clock (MDC) and shifts clause-22 read and write frames onto a tri-state data line, MDIO. The MDIO line is presented as a separate output value, output enable and input. A host starts a transaction with a one-cycle request carrying the direction, a 5-bit PHY address, a 5-bit register address and, for writes, 16 bits of data. The request is taken whenever the station is not busy.

Each request can leave out the 32-bit preamble, for targets that accept short frames. On a read the station lets go of the line for the turnaround and data slots and collects the 16 returned bits. It checks that the target pulled the second turnaround bit low. If the target did not, it raises a no-response flag instead of the data-valid flag. After every frame the line is left released for a programmed number of idle bit times, and only then does busy drop.

Top module: `mdio_station`

## Requirements
- R1: While reset is asserted and right after it is released, busy, done, rd_ok, no_resp, mdc and mdio_oe are all 0.
- R2: While busy, MDC toggles every max(div_half,2) system cycles. It first rises that many cycles after the accept edge, so its period is 2*max(div_half,2) cycles. While not busy, MDC stays 0.
- R3: A write without skip_pre sends 64 bits, MSB first within each field, one per MDC period, in this order: 32 ones, start 0,1, opcode 0,1, the PHY address, the register address, turnaround 1,0, then the 16 data bits.
- R4: With skip_pre set, the 32 preamble ones are left out and the frame begins directly with the start pattern 0,1.
- R5: A read uses opcode 1,0 and keeps mdio_oe at 0 for both turnaround slots and all 16 data slots. It samples MDIO at each MDC rising edge, and rd_data returns the 16 data-slot samples with the first one in bit 15.
- R6: A read whose second turnaround sample is 0 sets rd_ok=1 and no_resp=0. A read whose second turnaround sample is 1 sets rd_ok=0 and no_resp=1. A write clears both flags. The two flags are never 1 together.
- R7: A request (req_valid=1) is accepted on a clock edge when busy is 0, and busy is 1 from the next cycle on. Requests while busy are ignored: they neither change the frame in progress nor start a later one.
- R8: After the last data slot, mdio_oe is 0 for IDLE_BITS further MDC periods. Busy falls with the MDC falling edge that ends the last idle period, which is 2*d*IDLE_BITS+d-1 cycles after done, where d=max(div_half,2).
- R9: done is a one-cycle pulse, high one system cycle after the MDC rising edge that ends the last data slot. rd_data, rd_ok and no_resp take their new values with done. rd_data holds its value through write transactions.
- R10: The driven MDIO value and mdio_oe change only on the system clock edge right after an MDC rising edge, or on the accept edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| div_half | input | DIV_W | System cycles per MDC half period (values below 2 act as 2) |
| req_valid | input | 1 | Request strobe, taken when busy is 0 |
| req_read | input | 1 | 1 = read, 0 = write |
| req_skip_pre | input | 1 | 1 = send the frame without the preamble |
| req_phy | input | 5 | Target PHY address |
| req_reg | input | 5 | Target register address |
| req_wdata | input | 16 | Write data |
| busy | output | 1 | Transaction or idle gap in progress |
| done | output | 1 | One-cycle end-of-frame pulse |
| rd_data | output | 16 | Last read data |
| rd_ok | output | 1 | Last read got a turnaround zero |
| no_resp | output | 1 | Last read saw no turnaround zero |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | MDIO value to drive |
| mdio_oe | output | 1 | MDIO output enable |
| mdio_i | input | 1 | MDIO line as seen at the pad |

## Verification
All timing follows from d=max(div_half,2). MDC first rises d cycles after the accept edge and then every 2d cycles. done is due one cycle after the MDC rise that ends the last data slot, and busy falls 2d*IDLE_BITS+d-1 cycles after done. The bench samples on the falling system clock edge and counts cycles between these events, so each result is compared in the exact cycle it is due. Frame contents are checked bit by bit from what a PHY model sees on the line at each MDC rising edge. A per-cycle monitor flags any change of the driven MDIO value that does not follow an MDC rise or an accept.

// File: rtl/mdio_pkg.sv
package mdio_pkg;

  localparam int PRE_BITS   = 32;
  localparam int ADDR_BITS  = 5;
  localparam int HDR_BITS   = 4 + 2 * ADDR_BITS;
  localparam int TA_BITS    = 2;
  localparam int DATA_BITS  = 16;
  localparam int BODY_BITS  = HDR_BITS + TA_BITS + DATA_BITS;
  localparam int FRAME_BITS = PRE_BITS + BODY_BITS;
  localparam int SLOT_W     = $clog2(FRAME_BITS + 1);
  localparam int TA2_SLOT   = DATA_BITS + 1;

  typedef enum logic [1:0] {
    SEQ_IDLE  = 2'd0,
    SEQ_SHIFT = 2'd1,
    SEQ_GAP   = 2'd2
  } seq_state_e;

  typedef struct packed {
    logic                 rd;
    logic                 skip_pre;
    logic [ADDR_BITS-1:0] phy;
    logic [ADDR_BITS-1:0] regad;
    logic [DATA_BITS-1:0] wdata;
  } mdio_req_t;

  // Line values for every slot, first slot in the MSB.
  function automatic logic [FRAME_BITS-1:0] frame_bits(input mdio_req_t r);
    logic [1:0]           op;
    logic [1:0]           ta;
    logic [DATA_BITS-1:0] dat;
    op  = r.rd ? 2'b10 : 2'b01;
    ta  = r.rd ? 2'b11 : 2'b10;
    dat = r.rd ? {DATA_BITS{1'b1}} : r.wdata;
    return {{PRE_BITS{1'b1}}, 2'b01, op, r.phy, r.regad, ta, dat};
  endfunction

  // Drive enables per slot: a read hands the line over from turnaround on.
  function automatic logic [FRAME_BITS-1:0] frame_oe(input mdio_req_t r);
    if (r.rd) return {{(PRE_BITS + HDR_BITS){1'b1}}, {(TA_BITS + DATA_BITS){1'b0}}};
    return {FRAME_BITS{1'b1}};
  endfunction

endpackage

// File: rtl/mdio_clkgen.sv
module mdio_clkgen #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [DIV_W-1:0] div_half,
  output logic             mdc,
  output logic             rise_tick,
  output logic             fall_tick
);

  localparam logic [DIV_W-1:0] MIN_DIV = DIV_W'(2);

  logic [DIV_W-1:0] cnt_q, cnt_n;
  logic             mdc_q, mdc_n;
  logic [DIV_W-1:0] div_eff;
  logic             terminal;

  always_comb begin
    div_eff  = (div_half < MIN_DIV) ? MIN_DIV : div_half;
    terminal = run && (cnt_q >= div_eff - DIV_W'(1));
  end

  always_comb begin
    cnt_n = cnt_q;
    mdc_n = mdc_q;
    if (!run) begin
      cnt_n = '0;
      mdc_n = 1'b0;
    end else if (terminal) begin
      cnt_n = '0;
      mdc_n = ~mdc_q;
    end else begin
      cnt_n = cnt_q + DIV_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      mdc_q <= 1'b0;
    end else begin
      cnt_q <= cnt_n;
      mdc_q <= mdc_n;
    end
  end

  assign mdc       = mdc_q;
  assign rise_tick = terminal && !mdc_q;
  assign fall_tick = terminal && mdc_q;

  // R2: a running MDC only flips once the half-period count is used up
  p_mdc_edge_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (run && $past(run) && (mdc_q != $past(mdc_q))) |-> ($past(cnt_q) >= $past(div_eff) - DIV_W'(1)));

  // R2: MDC parks low once the station is idle
  p_mdc_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> !mdc_q);

endmodule

// File: rtl/mdio_frame_ctrl.sv
module mdio_frame_ctrl
  import mdio_pkg::*;
#(
  parameter int IDLE_BITS = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  mdio_req_t         req,
  input  logic              rise_tick,
  input  logic              fall_tick,
  output logic              busy,
  output logic              mdio_o,
  output logic              mdio_oe,
  output logic              rd_mode,
  output logic              step,
  output logic              frame_end,
  output logic [SLOT_W-1:0] slots_left
);

  localparam int GAP_W = $clog2(IDLE_BITS + 1);
  localparam logic [SLOT_W-1:0] LAST_SLOT  = SLOT_W'(1);
  localparam logic [SLOT_W-1:0] FULL_SLOTS = SLOT_W'(FRAME_BITS);
  localparam logic [SLOT_W-1:0] BODY_SLOTS = SLOT_W'(BODY_BITS);
  localparam logic [SLOT_W-1:0] RX_SLOTS   = SLOT_W'(TA_BITS + DATA_BITS);

  seq_state_e             state_q, state_n;
  logic [FRAME_BITS-1:0]  bits_q, bits_n;
  logic [FRAME_BITS-1:0]  oe_q, oe_n;
  logic [SLOT_W-1:0]      left_q, left_n;
  logic [GAP_W-1:0]       gap_q, gap_n;
  logic                   rd_q, rd_n;
  logic                   rise_d_q;

  always_comb begin
    state_n = state_q;
    bits_n  = bits_q;
    oe_n    = oe_q;
    left_n  = left_q;
    gap_n   = gap_q;
    rd_n    = rd_q;
    case (state_q)
      SEQ_IDLE: begin
        if (req_valid) begin
          state_n = SEQ_SHIFT;
          rd_n    = req.rd;
          if (req.skip_pre) begin
            bits_n = frame_bits(req) << PRE_BITS;
            oe_n   = frame_oe(req) << PRE_BITS;
            left_n = BODY_SLOTS;
          end else begin
            bits_n = frame_bits(req);
            oe_n   = frame_oe(req);
            left_n = FULL_SLOTS;
          end
        end
      end
      SEQ_SHIFT: begin
        if (rise_d_q) begin
          if (left_q == LAST_SLOT) begin
            state_n = SEQ_GAP;
            bits_n  = '1;
            oe_n    = '0;
            gap_n   = GAP_W'(IDLE_BITS);
          end else begin
            bits_n = {bits_q[FRAME_BITS-2:0], 1'b1};
            oe_n   = {oe_q[FRAME_BITS-2:0], 1'b0};
            left_n = left_q - SLOT_W'(1);
          end
        end
      end
      SEQ_GAP: begin
        if (rise_d_q && (gap_q != '0)) gap_n = gap_q - GAP_W'(1);
        if (fall_tick && (gap_q == '0)) state_n = SEQ_IDLE;
      end
      default: state_n = SEQ_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= SEQ_IDLE;
      bits_q   <= '1;
      oe_q     <= '0;
      left_q   <= '0;
      gap_q    <= '0;
      rd_q     <= 1'b0;
      rise_d_q <= 1'b0;
    end else begin
      state_q  <= state_n;
      bits_q   <= bits_n;
      oe_q     <= oe_n;
      left_q   <= left_n;
      gap_q    <= gap_n;
      rd_q     <= rd_n;
      rise_d_q <= rise_tick;
    end
  end

  assign busy       = (state_q != SEQ_IDLE);
  assign mdio_o     = bits_q[FRAME_BITS-1];
  assign mdio_oe    = oe_q[FRAME_BITS-1];
  assign rd_mode    = rd_q;
  assign step       = (state_q == SEQ_SHIFT) && rise_d_q;
  assign frame_end  = step && (left_q == LAST_SLOT);
  assign slots_left = left_q;

  // R5: during a read the station never drives turnaround or data slots
  p_read_release_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == SEQ_SHIFT && rd_q && left_q <= RX_SLOTS) |-> !mdio_oe);

  // R7: a request during a frame leaves the slot count alone
  p_busy_ignore_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == SEQ_SHIFT && req_valid && !rise_d_q) |=> $stable(left_q));

  // R8: the line stays released through the idle gap
  p_gap_release_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == SEQ_GAP) |-> !mdio_oe);

  // R10: driven value moves only right after an MDC rise
  p_drive_timing_r10: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(state_q) != SEQ_IDLE && !$past(rise_d_q)) |-> ($stable(mdio_o) && $stable(mdio_oe)));

endmodule

// File: rtl/mdio_rx_capture.sv
module mdio_rx_capture
  import mdio_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 mdio_i,
  input  logic                 rise_tick,
  input  logic                 step,
  input  logic                 frame_end,
  input  logic                 rd_mode,
  input  logic [SLOT_W-1:0]    slots_left,
  output logic                 done,
  output logic [DATA_BITS-1:0] rd_data,
  output logic                 rd_ok,
  output logic                 no_resp
);

  localparam logic [SLOT_W-1:0] TA2_AT   = SLOT_W'(TA2_SLOT);
  localparam logic [SLOT_W-1:0] DATA_TOP = SLOT_W'(DATA_BITS);

  logic                 sync1_q, sync2_q;
  logic                 samp_q;
  logic [DATA_BITS-1:0] shift_q, shift_n;
  logic                 ta_ok_q, ta_ok_n;
  logic                 done_q;
  logic [DATA_BITS-1:0] data_q, data_n;
  logic                 ok_q, ok_n;
  logic                 nr_q, nr_n;

  always_comb begin
    shift_n = shift_q;
    ta_ok_n = ta_ok_q;
    data_n  = data_q;
    ok_n    = ok_q;
    nr_n    = nr_q;
    if (step && rd_mode) begin
      if (slots_left == TA2_AT) ta_ok_n = !samp_q;
      if (slots_left <= DATA_TOP) shift_n = {shift_q[DATA_BITS-2:0], samp_q};
    end
    if (frame_end) begin
      if (rd_mode) data_n = {shift_q[DATA_BITS-2:0], samp_q};
      ok_n = rd_mode && ta_ok_q;
      nr_n = rd_mode && !ta_ok_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync1_q <= 1'b1;
      sync2_q <= 1'b1;
      samp_q  <= 1'b1;
      shift_q <= '0;
      ta_ok_q <= 1'b0;
      done_q  <= 1'b0;
      data_q  <= '0;
      ok_q    <= 1'b0;
      nr_q    <= 1'b0;
    end else begin
      sync1_q <= mdio_i;
      sync2_q <= sync1_q;
      if (rise_tick) samp_q <= sync2_q;
      shift_q <= shift_n;
      ta_ok_q <= ta_ok_n;
      done_q  <= frame_end;
      data_q  <= data_n;
      ok_q    <= ok_n;
      nr_q    <= nr_n;
    end
  end

  assign done    = done_q;
  assign rd_data = data_q;
  assign rd_ok   = ok_q;
  assign no_resp = nr_q;

  // R9: end-of-frame strobe lasts one cycle
  p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q);

  // R9: returned data only moves together with done
  p_data_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !done_q |-> $stable(data_q));

  // R6: valid and no-response are exclusive
  p_flag_excl_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !(ok_q && nr_q));

endmodule

// File: rtl/mdio_station.sv
module mdio_station
  import mdio_pkg::*;
#(
  parameter int DIV_W     = 8,
  parameter int IDLE_BITS = 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [DIV_W-1:0]     div_half,
  input  logic                 req_valid,
  input  logic                 req_read,
  input  logic                 req_skip_pre,
  input  logic [ADDR_BITS-1:0] req_phy,
  input  logic [ADDR_BITS-1:0] req_reg,
  input  logic [DATA_BITS-1:0] req_wdata,
  output logic                 busy,
  output logic                 done,
  output logic [DATA_BITS-1:0] rd_data,
  output logic                 rd_ok,
  output logic                 no_resp,
  output logic                 mdc,
  output logic                 mdio_o,
  output logic                 mdio_oe,
  input  logic                 mdio_i
);

  mdio_req_t         req;
  logic              busy_w;
  logic              rise_tick, fall_tick;
  logic              rd_mode, step, frame_end;
  logic [SLOT_W-1:0] slots_left;

  always_comb begin
    req.rd       = req_read;
    req.skip_pre = req_skip_pre;
    req.phy      = req_phy;
    req.regad    = req_reg;
    req.wdata    = req_wdata;
  end

  mdio_clkgen #(.DIV_W(DIV_W)) u_clkgen (
    .clk       (clk),
    .rst_n     (rst_n),
    .run       (busy_w),
    .div_half  (div_half),
    .mdc       (mdc),
    .rise_tick (rise_tick),
    .fall_tick (fall_tick)
  );

  mdio_frame_ctrl #(.IDLE_BITS(IDLE_BITS)) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req        (req),
    .rise_tick  (rise_tick),
    .fall_tick  (fall_tick),
    .busy       (busy_w),
    .mdio_o     (mdio_o),
    .mdio_oe    (mdio_oe),
    .rd_mode    (rd_mode),
    .step       (step),
    .frame_end  (frame_end),
    .slots_left (slots_left)
  );

  mdio_rx_capture u_rx (
    .clk        (clk),
    .rst_n      (rst_n),
    .mdio_i     (mdio_i),
    .rise_tick  (rise_tick),
    .step       (step),
    .frame_end  (frame_end),
    .rd_mode    (rd_mode),
    .slots_left (slots_left),
    .done       (done),
    .rd_data    (rd_data),
    .rd_ok      (rd_ok),
    .no_resp    (no_resp)
  );

  assign busy = busy_w;

  // R7: an idle station takes a request on the next edge
  p_accept_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_w && req_valid) |=> busy_w);

  // R1/R2: nothing toggles or drives while idle
  p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_w && !$past(busy_w)) |-> (!mdc && !mdio_oe));

endmodule

// File: tb/test_mdio_station.sv
`timescale 1ns/1ps
module test_mdio_station;

  logic        clk, rst_n;
  logic [7:0]  div_half;
  logic        req_valid, req_read, req_skip_pre;
  logic [4:0]  req_phy, req_reg;
  logic [15:0] req_wdata;
  logic        busy, done, rd_ok, no_resp, mdc, mdio_o, mdio_oe;
  logic [15:0] rd_data;
  logic        phy_drv, phy_val;
  wire         line = mdio_oe ? mdio_o : (phy_drv ? phy_val : 1'b1);

  int n_tests = 0, n_fail = 0;

  mdio_station i_mdio_station (
    .clk(clk), .rst_n(rst_n), .div_half(div_half),
    .req_valid(req_valid), .req_read(req_read), .req_skip_pre(req_skip_pre),
    .req_phy(req_phy), .req_reg(req_reg), .req_wdata(req_wdata),
    .busy(busy), .done(done), .rd_data(rd_data), .rd_ok(rd_ok), .no_resp(no_resp),
    .mdc(mdc), .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(line)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  // PHY model state
  logic [127:0] lg;
  int  nrise;
  bit  cur_read, resp_on;
  logic [15:0] resp_data;
  int  base;

  always @(posedge mdc) begin
    lg = {lg[126:0], line};
    nrise++;
    if (resp_on && cur_read) begin
      if (nrise == base + 1) begin
        phy_drv <= 1'b1;
        phy_val <= 1'b0;
      end else if (nrise >= base + 2 && nrise <= base + 17) begin
        phy_val <= resp_data[base + 17 - nrise];
      end else if (nrise == base + 18) begin
        phy_drv <= 1'b0;
      end
    end
  end

  // cycle monitor, sampled away from the active edge
  int  cyc = 0, nr2, t_rise, t_first, t_accept, t_endrise, t_done, t_bfall;
  int  nslots, exp_per, per_bad, done_cnt, done_wide, viol = 0, idle_mdc = 0;
  logic mdc_p = 0, mdc_p2 = 0, busy_p = 0, done_p = 0;
  logic [1:0] drv_p = 2'b00;

  always @(negedge clk) begin
    logic [1:0] cur;
    cyc++;
    cur = {mdio_oe, mdio_oe & mdio_o};
    if (rst_n) begin
      if (mdc && !mdc_p) begin
        nr2++;
        if (nr2 == 1) t_first = cyc;
        else if (cyc - t_rise != exp_per) per_bad++;
        if (nr2 == nslots) t_endrise = cyc;
        t_rise = cyc;
      end
      if (busy && !busy_p) t_accept = cyc;
      if (!busy && busy_p) t_bfall = cyc;
      if (done) begin
        done_cnt++;
        if (done_p) done_wide++;
        t_done = cyc;
      end
      if (!busy && mdc) idle_mdc++;
      if (cur != drv_p && !(mdc_p && !mdc_p2) && !(busy && !busy_p)) viol++;
    end
    mdc_p2 = mdc_p; mdc_p = mdc; busy_p = busy; done_p = done; drv_p = cur;
  end

  task automatic check(input bit ok, input string tag, input string what,
                       input logic [127:0] act, input logic [127:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  function automatic logic [127:0] exp_bits(bit rd, bit nopre, bit resp,
      logic [4:0] p, logic [4:0] r, logic [15:0] d);
    logic [31:0] body;
    if (!rd)       body = {4'b0101, p, r, 2'b10, d};
    else if (resp) body = {4'b0110, p, r, 2'b10, d};
    else           body = {4'b0110, p, r, 2'b11, 16'hFFFF};
    if (nopre) return {95'b0, body, 1'b1};
    return {63'b0, 32'hFFFF_FFFF, body, 1'b1};
  endfunction

  task automatic run_txn(input bit rd, input bit nopre, input bit resp,
      input logic [4:0] p, input logic [4:0] r, input logic [15:0] d,
      input logic [7:0] dh, input bit inject);
    int d_eff;
    d_eff = (dh < 2) ? 2 : int'(dh);
    div_half = dh;
    lg = '0; nrise = 0; nr2 = 0; per_bad = 0; done_cnt = 0; done_wide = 0;
    phy_drv = 1'b0; phy_val = 1'b1;
    cur_read = rd; resp_on = resp; resp_data = d;
    base = nopre ? 14 : 46;
    nslots = nopre ? 32 : 64;
    exp_per = 2 * d_eff;
    @(negedge clk);
    req_read = rd; req_skip_pre = nopre; req_phy = p; req_reg = r; req_wdata = d;
    req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    if (inject) begin
      repeat (40) @(negedge clk);
      req_read = ~rd; req_skip_pre = ~nopre; req_phy = ~p; req_reg = ~r; req_wdata = ~d;
      req_valid = 1'b1;
      repeat (3) @(negedge clk);
      req_valid = 1'b0;
    end
    while (busy) @(negedge clk);
    @(negedge clk);
  endtask

  function automatic logic [127:0] msk(int n);
    return (128'b1 << n) - 128'b1;
  endfunction

  task automatic test_reset();
    check(!busy && !done && !mdc && !mdio_oe && !rd_ok && !no_resp, "R1",
          "outputs after reset", {busy, done, mdc, mdio_oe, rd_ok, no_resp}, 0);
  endtask

  task automatic test_write_full();
    logic [127:0] e;
    e = exp_bits(0, 0, 0, 5'h13, 5'h05, 16'hA5C3);
    run_txn(0, 0, 0, 5'h13, 5'h05, 16'hA5C3, 8'd2, 0);
    check((lg & msk(65)) == e && nrise == 65, "R3", "full write line bits", lg & msk(65), e);
    check(per_bad == 0, "R2", "MDC period 4", per_bad, 0);
    check(t_first - t_accept == 2, "R2", "first MDC rise delay", t_first - t_accept, 2);
    check(idle_mdc == 0, "R2", "MDC low while idle", idle_mdc, 0);
    check(done_cnt == 1 && done_wide == 0, "R9", "done single pulse", done_cnt, 1);
    check(t_done - t_endrise == 1, "R9", "done after last rise", t_done - t_endrise, 1);
    check(t_bfall - t_done == 5, "R8", "gap length d=2", t_bfall - t_done, 5);
    check(!rd_ok && !no_resp, "R6", "write clears flags", {rd_ok, no_resp}, 0);
    check(viol == 0, "R10", "drive changes only after MDC rise", viol, 0);
  endtask

  task automatic test_write_nopre();
    logic [127:0] e;
    e = exp_bits(0, 1, 0, 5'h0A, 5'h1F, 16'h0F01);
    run_txn(0, 1, 0, 5'h0A, 5'h1F, 16'h0F01, 8'd3, 0);
    check((lg & msk(33)) == e && nrise == 33, "R4", "short write line bits", lg & msk(33), e);
    check(per_bad == 0, "R2", "MDC period 6", per_bad, 0);
    check(t_bfall - t_done == 8, "R8", "gap length d=3", t_bfall - t_done, 8);
  endtask

  task automatic test_read_ok();
    logic [127:0] e;
    e = exp_bits(1, 0, 1, 5'h01, 5'h02, 16'h9C35);
    run_txn(1, 0, 1, 5'h01, 5'h02, 16'h9C35, 8'd2, 0);
    check((lg & msk(65)) == e, "R5", "read line bits", lg & msk(65), e);
    check(rd_data == 16'h9C35, "R5", "read data", rd_data, 16'h9C35);
    check(rd_ok && !no_resp, "R6", "read flags ok", {rd_ok, no_resp}, 2'b10);
    check(t_done - t_endrise == 1, "R9", "read done timing", t_done - t_endrise, 1);
  endtask

  task automatic test_read_nopre_fastdiv();
    logic [127:0] e;
    e = exp_bits(1, 1, 1, 5'h1E, 5'h11, 16'h4002);
    run_txn(1, 1, 1, 5'h1E, 5'h11, 16'h4002, 8'd1, 0);
    check((lg & msk(33)) == e, "R5", "short read line bits", lg & msk(33), e);
    check(rd_data == 16'h4002, "R4", "short read data", rd_data, 16'h4002);
    check(per_bad == 0, "R2", "div 1 clamps to period 4", per_bad, 0);
  endtask

  task automatic test_read_noresp();
    run_txn(1, 0, 0, 5'h07, 5'h03, 16'h1234, 8'd2, 0);
    check(!rd_ok && no_resp, "R6", "no response flags", {rd_ok, no_resp}, 2'b01);
  endtask

  task automatic test_hold();
    run_txn(1, 1, 1, 5'h02, 5'h04, 16'h5A5A, 8'd2, 0);
    run_txn(0, 1, 0, 5'h02, 5'h04, 16'h0001, 8'd2, 0);
    check(rd_data == 16'h5A5A, "R9", "rd_data held over write", rd_data, 16'h5A5A);
  endtask

  task automatic test_busy_ignore();
    logic [127:0] e;
    int n_after;
    e = exp_bits(0, 1, 0, 5'h15, 5'h0C, 16'hBEEF);
    run_txn(0, 1, 0, 5'h15, 5'h0C, 16'hBEEF, 8'd2, 1);
    check((lg & msk(33)) == e && nrise == 33, "R7", "frame unchanged by busy request",
          lg & msk(33), e);
    check(done_cnt == 1, "R7", "one done only", done_cnt, 1);
    n_after = nrise;
    repeat (60) @(negedge clk);
    check(!busy && nrise == n_after, "R7", "no second frame", nrise, n_after);
  endtask

  initial begin
    rst_n = 1'b0; div_half = 8'd2; req_valid = 1'b0; req_read = 1'b0;
    req_skip_pre = 1'b0; req_phy = '0; req_reg = '0; req_wdata = '0;
    phy_drv = 1'b0; phy_val = 1'b1; lg = '0; nrise = 0;
    cur_read = 0; resp_on = 0; resp_data = '0; base = 0;
    nr2 = 0; nslots = 0; exp_per = 0; per_bad = 0; done_cnt = 0; done_wide = 0;
    t_rise = 0; t_first = 0; t_accept = 0; t_endrise = 0; t_done = 0; t_bfall = 0;
    repeat (3) @(negedge clk);
    test_reset();
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    test_reset();
    test_write_full();
    test_write_nopre();
    test_read_ok();
    test_read_nopre_fastdiv();
    test_read_noresp();
    test_hold();
    test_busy_ignore();
    check(viol == 0, "R10", "drive timing over all frames", viol, 0);
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule